// File: doc/BRIEF.md
# SMBus Host Notify Receiver

This block sits on the host side of an SMBus segment and handles the case where some other device becomes bus master to tell the host about an event. A byte-level slave front end passes it three kinds of events: START, STOP and a received byte. For every received byte the block decides in that same cycle whether the byte is acknowledged. The frame it accepts has the shape of a write-word transfer: the host's own address with the write bit, then the notifying device's address in the slot where a command code would normally sit, then a 16-bit value sent low byte first.

When a frame ends correctly, the block latches the device address and the data word and raises a sticky interrupt. The interrupt and the values stay put until software pulses a clear. A frame that is damaged, cut short or too long leaves no trace. The block never drives data back onto the bus. Bit-level SCL/SDA handling is done upstream and is not part of this block.

Top module: `smbn_notify_rx`

## Requirements
- R1: After reset, irq_o and overrun_o are 0, dev_addr_o is 0 and data_o is 0.
- R2: The first byte after a START is acknowledged (ack_o high in the same cycle as ev_byte_valid_i) only if bits 7:1 equal own_addr_i and bit 0, the read/write bit, is 0 (write).
- R3: If the first byte after a START fails that match, it and every later byte up to the next START are not acknowledged, and the frame raises no interrupt.
- R4: After a matching first byte, the next three bytes (device address, low data, high data) are each acknowledged in their own cycle.
- R5: A STOP that arrives after exactly three data bytes sets irq_o from the cycle after the STOP. In that same cycle dev_addr_o equals bits 7:1 of the device byte and data_o equals {high byte, low byte}.
- R6: Bit 0 of the device-address byte has no effect on dev_addr_o.
- R7: A STOP that arrives after fewer than three data bytes raises no interrupt.
- R8: A START in the middle of a frame drops the partial frame, and the new frame is decoded from its first byte.
- R9: A fourth data byte is not acknowledged, and the frame it belongs to raises no interrupt.
- R10: A valid notification that completes while irq_o is set and no clear is present sets overrun_o. It leaves dev_addr_o and data_o unchanged.
- R11: A clr_i pulse drops irq_o and overrun_o in the next cycle. If a valid notification completes in the same cycle as the clear, that notification is latched as a fresh one: irq_o stays 1 with the new values and overrun_o is 0.
- R12: A byte that arrives before any START is not acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| own_addr_i | input | 7 | The host's own 7-bit slave address |
| ev_start_i | input | 1 | START or repeated START seen on the bus |
| ev_stop_i | input | 1 | STOP seen on the bus |
| ev_byte_valid_i | input | 1 | A received byte is present on ev_byte_i |
| ev_byte_i | input | 8 | Received byte |
| ack_o | output | 1 | Acknowledge decision for the current byte (combinational) |
| clr_i | input | 1 | Software clear of the interrupt and the overrun flag |
| irq_o | output | 1 | Sticky notification interrupt |
| overrun_o | output | 1 | A further notification was dropped while irq_o was pending |
| dev_addr_o | output | 7 | Address of the device that sent the notification |
| data_o | output | 16 | Notification data word |

## Verification
ack_o is combinational, so the bench samples it in the same cycle it drives a byte: a few nanoseconds after the falling edge that applied the byte, and before the rising edge. irq_o, overrun_o, dev_addr_o and data_o pass through one register after the STOP or clear event. The bench therefore checks them one nanosecond after the rising edge that sampled that event, while the input is already deasserted. Every event is held for exactly one clock, so each check has exactly one cycle in which it can be right.

// File: rtl/smbn_pkg.sv
package smbn_pkg;

    localparam int ADDR_W     = 7;
    localparam int BYTE_W     = 8;
    localparam int WORD_BYTES = 2;
    localparam int WORD_W     = BYTE_W * WORD_BYTES;
    // device byte plus the word bytes
    localparam int BODY_BYTES = 1 + WORD_BYTES;
    localparam int CNT_W      = $clog2(BODY_BYTES + 1);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_BODY,
        ST_FULL,
        ST_DROP
    } frame_st_e;

    typedef struct packed {
        logic [ADDR_W-1:0] dev;
        logic [WORD_W-1:0] word;
    } notice_t;

    // write direction is read/write bit == 0
    function automatic logic addr_hit(input logic [BYTE_W-1:0] b,
                                      input logic [ADDR_W-1:0] own);
        return (b[BYTE_W-1:1] == own) && !b[0];
    endfunction

endpackage

// File: rtl/smbn_frame_fsm.sv
module smbn_frame_fsm
    import smbn_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] own_addr_i,
    input  logic              ev_start_i,
    input  logic              ev_stop_i,
    input  logic              ev_byte_valid_i,
    input  logic [BYTE_W-1:0] ev_byte_i,
    output logic              ack_o,
    output logic              done_o,
    output notice_t           notice_o
);

    frame_st_e         st_q, st_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    notice_t           cap_q, cap_d;

    always_comb begin
        st_d   = st_q;
        cnt_d  = cnt_q;
        cap_d  = cap_q;
        ack_o  = 1'b0;
        done_o = 1'b0;
        if (ev_start_i) begin
            st_d  = ST_ADDR;
            cnt_d = '0;
        end else if (ev_stop_i) begin
            done_o = (st_q == ST_FULL);
            st_d   = ST_IDLE;
        end else if (ev_byte_valid_i) begin
            unique case (st_q)
                ST_ADDR: begin
                    if (addr_hit(ev_byte_i, own_addr_i)) begin
                        ack_o = 1'b1;
                        st_d  = ST_BODY;
                        cnt_d = '0;
                    end else begin
                        st_d = ST_DROP;
                    end
                end
                ST_BODY: begin
                    ack_o = 1'b1;
                    if (cnt_q == '0) begin
                        cap_d.dev = ev_byte_i[BYTE_W-1:1];
                    end else begin
                        cap_d.word[(int'(cnt_q) - 1) * BYTE_W +: BYTE_W] = ev_byte_i;
                    end
                    cnt_d = cnt_q + 1'b1;
                    if (int'(cnt_q) == BODY_BYTES - 1) begin
                        st_d = ST_FULL;
                    end
                end
                ST_FULL: st_d = ST_DROP;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
            cap_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
            cap_q <= cap_d;
        end
    end

    assign notice_o = cap_q;

endmodule

// File: rtl/smbn_hold.sv
module smbn_hold
    import smbn_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    done_i,
    input  notice_t notice_i,
    input  logic    clr_i,
    output logic    irq_o,
    output logic    overrun_o,
    output notice_t notice_o
);

    logic    pend;
    notice_t held_q;

    assign pend = irq_o && !clr_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_o     <= 1'b0;
            overrun_o <= 1'b0;
            held_q    <= '0;
        end else begin
            if (clr_i) begin
                irq_o     <= 1'b0;
                overrun_o <= 1'b0;
            end
            if (done_i) begin
                if (pend) begin
                    overrun_o <= 1'b1;
                end else begin
                    irq_o  <= 1'b1;
                    held_q <= notice_i;
                end
            end
        end
    end

    assign notice_o = held_q;

endmodule

// File: rtl/smbn_notify_rx.sv
module smbn_notify_rx
    import smbn_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] own_addr_i,
    input  logic              ev_start_i,
    input  logic              ev_stop_i,
    input  logic              ev_byte_valid_i,
    input  logic [BYTE_W-1:0] ev_byte_i,
    output logic              ack_o,
    input  logic              clr_i,
    output logic              irq_o,
    output logic              overrun_o,
    output logic [ADDR_W-1:0] dev_addr_o,
    output logic [WORD_W-1:0] data_o
);

    logic    done;
    notice_t cap;
    notice_t held;

    smbn_frame_fsm u_fsm (
        .clk             (clk),
        .rst             (rst),
        .own_addr_i      (own_addr_i),
        .ev_start_i      (ev_start_i),
        .ev_stop_i       (ev_stop_i),
        .ev_byte_valid_i (ev_byte_valid_i),
        .ev_byte_i       (ev_byte_i),
        .ack_o           (ack_o),
        .done_o          (done),
        .notice_o        (cap)
    );

    smbn_hold u_hold (
        .clk       (clk),
        .rst       (rst),
        .done_i    (done),
        .notice_i  (cap),
        .clr_i     (clr_i),
        .irq_o     (irq_o),
        .overrun_o (overrun_o),
        .notice_o  (held)
    );

    assign dev_addr_o = held.dev;
    assign data_o     = held.word;

endmodule

// File: rtl/smbn_notify_rx_chk.sv
module smbn_notify_rx_chk
    import smbn_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              ev_stop_i,
    input logic              ev_byte_valid_i,
    input logic              ack_o,
    input logic              clr_i,
    input logic              irq_o,
    input logic              overrun_o,
    input logic [ADDR_W-1:0] dev_addr_o,
    input logic [WORD_W-1:0] data_o
);

    // R4
    ack_needs_byte_chk: assert property (@(posedge clk) disable iff (rst)
        ack_o |-> ev_byte_valid_i);

    // R5
    irq_after_stop_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_o) |-> $past(ev_stop_i));

    // R10
    held_stable_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(irq_o) && !$past(clr_i)) |-> ($stable(dev_addr_o) && $stable(data_o)));

    // R10
    overrun_with_irq_chk: assert property (@(posedge clk) disable iff (rst)
        overrun_o |-> irq_o);

    // R11
    clear_overrun_chk: assert property (@(posedge clk) disable iff (rst)
        clr_i |=> !overrun_o);

endmodule

bind smbn_notify_rx smbn_notify_rx_chk u_chk (
    .clk             (clk),
    .rst             (rst),
    .ev_stop_i       (ev_stop_i),
    .ev_byte_valid_i (ev_byte_valid_i),
    .ack_o           (ack_o),
    .clr_i           (clr_i),
    .irq_o           (irq_o),
    .overrun_o       (overrun_o),
    .dev_addr_o      (dev_addr_o),
    .data_o          (data_o)
);

// File: tb/sim_smbn_notify_rx.sv
`timescale 1ns/1ps
module sim_smbn_notify_rx;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [6:0]  own_addr_i = 7'h08;
    logic        ev_start_i = 1'b0;
    logic        ev_stop_i = 1'b0;
    logic        ev_byte_valid_i = 1'b0;
    logic [7:0]  ev_byte_i = 8'h00;
    logic        ack_o;
    logic        clr_i = 1'b0;
    logic        irq_o;
    logic        overrun_o;
    logic [6:0]  dev_addr_o;
    logic [15:0] data_o;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    smbn_notify_rx u0 (.*);

    // {own, addr byte, dev byte, low, high, expect irq} = 7+8+8+8+8+1 = 40 bits
    localparam logic [39:0] VEC [5] = '{
        {7'h08, 8'h10, 8'h54, 8'h34, 8'h12, 1'b1},
        {7'h08, 8'h11, 8'h54, 8'h34, 8'h12, 1'b0},
        {7'h08, 8'h12, 8'h54, 8'h34, 8'h12, 1'b0},
        {7'h7F, 8'hFE, 8'h55, 8'hFF, 8'h00, 1'b1},
        {7'h00, 8'h00, 8'h03, 8'hA5, 8'h5A, 1'b1}
    };

    task automatic chk(input logic ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // one event per clock; ack sampled before the edge, state after it
    task automatic ev(input logic st, input logic sp, input logic bv,
                      input logic [7:0] b, input logic cl, output logic a);
        @(negedge clk);
        ev_start_i = st; ev_stop_i = sp; ev_byte_valid_i = bv;
        ev_byte_i = b; clr_i = cl;
        #2 a = ack_o;
        @(posedge clk);
        #1;
        ev_start_i = 0; ev_stop_i = 0; ev_byte_valid_i = 0; clr_i = 0;
    endtask

    task automatic byte_ack(input logic [7:0] b, input logic exp, input string req);
        logic a;
        ev(0, 0, 1, b, 0, a);
        chk(a == exp, req, a, exp);
    endtask

    task automatic do_start();
        logic a;
        ev(1, 0, 0, 8'h00, 0, a);
    endtask

    task automatic do_stop(input logic cl);
        logic a;
        ev(0, 1, 0, 8'h00, cl, a);
    endtask

    task automatic do_clear();
        logic a;
        ev(0, 0, 0, 8'h00, 1, a);
    endtask

    initial begin
        #4_000_000;
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 0;
        // R1 reset state
        chk(irq_o == 0 && overrun_o == 0, "R1 flags", {irq_o, overrun_o}, 0);
        chk(dev_addr_o == 0 && data_o == 0, "R1 values", {dev_addr_o, data_o}, 0);

        // R12 byte outside any frame
        byte_ack(8'h10, 0, "R12");

        for (int i = 0; i < 5; i++) begin
            logic m;
            own_addr_i = VEC[i][39:33];
            m = VEC[i][0];
            do_start();
            byte_ack(VEC[i][32:25], m, "R2/R3 addr");
            byte_ack(VEC[i][24:17], m, "R4/R3 dev");
            byte_ack(VEC[i][16:9],  m, "R4/R3 low");
            byte_ack(VEC[i][8:1],   m, "R4/R3 high");
            do_stop(0);
            chk(irq_o == m, "R5/R3 irq", irq_o, m);
            if (m) begin
                chk(dev_addr_o == VEC[i][24:18], "R5/R6 dev", dev_addr_o, VEC[i][24:18]);
                chk(data_o == {VEC[i][8:1], VEC[i][16:9]}, "R5 data", data_o,
                    {VEC[i][8:1], VEC[i][16:9]});
            end
            do_clear();
            chk(irq_o == 0, "R11 clear", irq_o, 0);
        end

        own_addr_i = 7'h08;
        // R7 early stop
        do_start();
        byte_ack(8'h10, 1, "R7 addr");
        byte_ack(8'h20, 1, "R7 dev");
        byte_ack(8'h01, 1, "R7 low");
        do_stop(0);
        chk(irq_o == 0, "R7 no irq", irq_o, 0);

        // R9 extra byte
        do_start();
        byte_ack(8'h10, 1, "R9 addr");
        byte_ack(8'h20, 1, "R9 dev");
        byte_ack(8'h01, 1, "R9 low");
        byte_ack(8'h02, 1, "R9 high");
        byte_ack(8'h03, 0, "R9 extra");
        do_stop(0);
        chk(irq_o == 0, "R9 no irq", irq_o, 0);

        // R8 repeated start restarts decoding
        do_start();
        byte_ack(8'h10, 1, "R8 addr1");
        byte_ack(8'h66, 1, "R8 dev1");
        do_start();
        byte_ack(8'h10, 1, "R8 addr2");
        byte_ack(8'h44, 1, "R8 dev2");
        byte_ack(8'hCD, 1, "R8 low2");
        byte_ack(8'hAB, 1, "R8 high2");
        do_stop(0);
        chk(irq_o == 1 && dev_addr_o == 7'h22, "R8 irq/dev", {irq_o, dev_addr_o}, {1'b1, 7'h22});
        chk(data_o == 16'hABCD, "R8 data", data_o, 16'hABCD);

        // R10 overrun while pending
        do_start();
        byte_ack(8'h10, 1, "R10 addr");
        byte_ack(8'h0E, 1, "R10 dev");
        byte_ack(8'h11, 1, "R10 low");
        byte_ack(8'h22, 1, "R10 high");
        do_stop(0);
        chk(overrun_o == 1 && irq_o == 1, "R10 overrun", {overrun_o, irq_o}, 2'b11);
        chk(dev_addr_o == 7'h22 && data_o == 16'hABCD, "R10 held",
            {dev_addr_o, data_o}, {7'h22, 16'hABCD});

        // R11 clear together with a completing frame
        do_start();
        byte_ack(8'h10, 1, "R11 addr");
        byte_ack(8'h0E, 1, "R11 dev");
        byte_ack(8'h11, 1, "R11 low");
        byte_ack(8'h22, 1, "R11 high");
        do_stop(1);
        chk(irq_o == 1 && overrun_o == 0, "R11 fresh flags", {irq_o, overrun_o}, 2'b10);
        chk(dev_addr_o == 7'h07 && data_o == 16'h2211, "R11 fresh values",
            {dev_addr_o, data_o}, {7'h07, 16'h2211});
        do_clear();
        chk(irq_o == 0 && overrun_o == 0, "R11 clear", {irq_o, overrun_o}, 0);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule